// File: doc/BRIEF.md
# Dual 32-bit Event Timer

This peripheral holds two independent 32-bit up-counters, a low half and a high half. Each half compares its count against its own period register once per divided tick. On a match it raises a one-clock event pulse and restarts from zero. Software reaches all state through a word-wide register bus. A write is taken when `bus_sel` and `bus_we` are high at a rising clock edge. Reads are combinational on `bus_rdata`.

Each half is built around a three-state machine: `ST_OFF`, `ST_ONCE` and `ST_CONT`, held in the half's 2-bit enable-mode field. The state machine moves as follows:

- A control-register write moves the half to the state that matches the written field value. This write can come from any state.
- In `ST_ONCE`, a count match moves the half back to `ST_OFF`.
- `ST_CONT` stays where it is on a match.
- `ST_OFF` leaves only through a bus write.

A shared divider creates the tick from the core clock.

The global control register lets a half count only when two conditions hold: the half's release bit is set, and the timer-mode field selects dual unchained 32-bit operation. Fields for features outside this block's function are stored and read back but steer nothing. These fields cover the watchdog, the chained modes, the external clock, input inversion, the pulse width and the prescaler.

Top module: `dual_event_timer`

## Requirements
- R1: After reset, every register reads 0 and `tout_lo`, `tout_hi` and `irq` are 0.
- R2: The byte offsets are as follows. Emulation/clock-speed is at 0x04, low counter at 0x10, high counter at 0x14, low period at 0x18, high period at 0x1C, control at 0x20, global control at 0x24 and watchdog control at 0x28. Offsets 0x00, 0x08 and 0x0C read 0 and ignore writes. Stored registers read back what was written.
- R3: Continuous mode is selected by control bits [7:6] = 10 for the low half and bits [23:22] = 10 for the high half. With period P and a counter cleared to 0, the half emits events P+1 ticks after the enabling write edge, and then every P+1 ticks.
- R4: One-shot mode (field = 01) emits exactly one event. The field then reads 00 and the counter reads 0.
- R5: Writing 00 to a mode field stops the half at once and holds its counter value. Writing 11 acts as 00 and reads back as 00.
- R6: A half counts only while its release bit is set and global control bits [3:2] = 01. The release bit is bit 0 for the low half and bit 1 for the high half.
- R7: A tick occurs once every D core clocks, where D is emulation/clock-speed bits [19:16]. A value of D = 0 acts as 1.
- R8: Each event drives its output for one clock. `tout_lo` equals the event XOR control bit 1, and `tout_hi` equals the event XOR control bit 17. Control bits 0 and 16 read the current `tout_lo` and `tout_hi` levels.
- R9: `irq` equals the low-half event gated by control bit 9.
- R10: A counter write loads the value at that edge, even while the half is running. Counting then continues from the written value.
- R11: The following fields are stored and read back with no effect on counting or events: control bits 2, 3, [5:4] and 8, global control bits [15:8], and the watchdog register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| tout_lo | output | 1 | Low-half event output after inversion |
| tout_hi | output | 1 | High-half event output after inversion |
| irq | output | 1 | Interrupt: low-half event when enabled |

## Verification
The embedded assertions check several properties on every cycle:

- A one-shot match always returns the half to `ST_OFF`.
- A half held off, or gated by its release or mode bits, never changes its counter.
- An event never lasts two clocks while the period is non-zero.
- Divided ticks never come back to back when the divisor exceeds one.

Other behaviour can only be shown by the bench's scenarios, which predict exact event cycles through a scoreboard. These scenarios cover the following:

- the absolute event cycles in continuous and one-shot runs, including both halves running together;
- the held count after a stop;
- the resumed sequence after a counter write mid-run;
- the event spacing under a divisor of three;
- output inversion and the status bits;
- readback of the stored fields that have no effect.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 6;
    localparam int HALF_SPAN = 16;   // high-half control bits sit 16 above the low ones
    localparam int STAT_BIT  = 0;
    localparam int INV_BIT   = 1;
    localparam int MODE_LSB  = 6;
    localparam int IEN_BIT   = 9;
    localparam int DIV_LSB   = 16;
    localparam int GMODE_LSB = 2;
    localparam logic [1:0] GMODE_DUAL = 2'b01;

    localparam logic [ADDR_W-1:0] OFS_EMU    = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_PRD_LO = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_PRD_HI = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_CTL    = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_GCTL   = 6'h24;
    localparam logic [ADDR_W-1:0] OFS_WDOG   = 6'h28;

    typedef enum logic [1:0] {
        ST_OFF  = 2'b00,
        ST_ONCE = 2'b01,
        ST_CONT = 2'b10
    } half_state_e;

    function automatic half_state_e mode_from_bits(input logic [1:0] b);
        case (b)
            2'b01:   return ST_ONCE;
            2'b10:   return ST_CONT;
            default: return ST_OFF;
        endcase
    endfunction

endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] eff;
    logic [DIV_W-1:0] last;

    assign eff    = (div_i == '0) ? DIV_W'(1) : div_i;
    assign last   = eff - DIV_W'(1);
    assign tick_o = (phase_q >= last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      phase_q <= '0;
        else if (tick_o) phase_q <= '0;
        else             phase_q <= phase_q + DIV_W'(1);
    end

    // R7: with a divisor above one, two ticks never fall on adjacent clocks
    p_tick_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i > DIV_W'(1)) |=> (!tick_o || div_i <= DIV_W'(1)))
        else $error("tick spacing violated");

endmodule

// File: rtl/timer_half.sv
module timer_half
    import dual_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_en_i,
    input  logic             mode_wr_i,
    input  logic [1:0]       mode_wdata_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    input  logic             prd_wr_i,
    input  logic [CNT_W-1:0] prd_wdata_i,
    output half_state_e      state_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] prd_o,
    output logic             evt_o
);
    half_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, prd_q;
    logic             evt_q;
    logic             live, fire;

    assign live = tick_i && run_en_i && (state_q != ST_OFF);
    assign fire = live && (cnt_q == prd_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next state: a bus write of the mode field overrides the automatic move
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  state_d = ST_OFF;
            ST_ONCE: if (fire) state_d = ST_OFF;
            ST_CONT: state_d = ST_CONT;
            default: state_d = ST_OFF;
        endcase
        if (mode_wr_i) state_d = mode_from_bits(mode_wdata_i);
    end

    // counter and period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            prd_q <= '0;
        end else begin
            if (cnt_wr_i)  cnt_q <= cnt_wdata_i;
            else if (fire) cnt_q <= '0;
            else if (live) cnt_q <= cnt_q + CNT_W'(1);
            if (prd_wr_i)  prd_q <= prd_wdata_i;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= fire;
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;
    assign prd_o   = prd_q;
    assign evt_o   = evt_q;

    // R4: a one-shot match without a competing write returns to off
    p_once_exits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ONCE && fire && !mode_wr_i) |=> (state_q == ST_OFF))
        else $error("one-shot did not stop");

    // R5: an idle half keeps its count
    p_hold_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && !cnt_wr_i) |=> $stable(cnt_q))
        else $error("counter moved while off");

    // R6: a gated half keeps its count
    p_gated_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en_i && !cnt_wr_i) |=> $stable(cnt_q))
        else $error("counter moved while gated");

    // R8: an event lasts one clock while the period is non-zero
    p_evt_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q && prd_q != '0 && !prd_wr_i && !cnt_wr_i) |=> !evt_q)
        else $error("event longer than one clock");

endmodule

// File: rtl/dual_event_timer.sv
module dual_event_timer
    import dual_timer_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DIV_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        tout_lo,
    output logic        tout_hi,
    output logic        irq
);
    localparam int NUM_HALF = 2;

    logic [DATA_W-1:0] emu_q, ctl_q, gctl_q, wdog_q, ctl_rd;
    logic              wr, tick;
    half_state_e       st  [NUM_HALF];
    logic [CNT_W-1:0]  cnt [NUM_HALF];
    logic [CNT_W-1:0]  prd [NUM_HALF];
    logic [NUM_HALF-1:0] evt, tout;

    assign wr = bus_sel && bus_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            emu_q  <= '0;
            ctl_q  <= '0;
            gctl_q <= '0;
            wdog_q <= '0;
        end else if (wr) begin
            case (bus_addr)
                OFS_EMU:  emu_q  <= bus_wdata;
                OFS_CTL:  ctl_q  <= bus_wdata;
                OFS_GCTL: gctl_q <= bus_wdata;
                OFS_WDOG: wdog_q <= bus_wdata;
                default:  ;
            endcase
        end
    end

    tick_divider #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (emu_q[DIV_LSB +: DIV_W]),
        .tick_o (tick)
    );

    for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
        localparam int CB = HALF_SPAN * h;
        localparam logic [ADDR_W-1:0] CNT_OFS = (h == 0) ? OFS_CNT_LO : OFS_CNT_HI;
        localparam logic [ADDR_W-1:0] PRD_OFS = (h == 0) ? OFS_PRD_LO : OFS_PRD_HI;

        timer_half #(.CNT_W(CNT_W)) u_half (
            .clk          (clk),
            .rst_n        (rst_n),
            .tick_i       (tick),
            .run_en_i     (gctl_q[h] && gctl_q[GMODE_LSB +: 2] == GMODE_DUAL),
            .mode_wr_i    (wr && bus_addr == OFS_CTL),
            .mode_wdata_i (bus_wdata[CB + MODE_LSB +: 2]),
            .cnt_wr_i     (wr && bus_addr == CNT_OFS),
            .cnt_wdata_i  (bus_wdata[CNT_W-1:0]),
            .prd_wr_i     (wr && bus_addr == PRD_OFS),
            .prd_wdata_i  (bus_wdata[CNT_W-1:0]),
            .state_o      (st[h]),
            .cnt_o        (cnt[h]),
            .prd_o        (prd[h]),
            .evt_o        (evt[h])
        );

        assign tout[h] = evt[h] ^ ctl_q[CB + INV_BIT];
    end

    always_comb begin
        ctl_rd = ctl_q;
        for (int h = 0; h < NUM_HALF; h++) begin
            ctl_rd[HALF_SPAN*h + MODE_LSB +: 2] = st[h];
            ctl_rd[HALF_SPAN*h + STAT_BIT]      = tout[h];
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_EMU:    bus_rdata = emu_q;
            OFS_CNT_LO: bus_rdata = DATA_W'(cnt[0]);
            OFS_CNT_HI: bus_rdata = DATA_W'(cnt[1]);
            OFS_PRD_LO: bus_rdata = DATA_W'(prd[0]);
            OFS_PRD_HI: bus_rdata = DATA_W'(prd[1]);
            OFS_CTL:    bus_rdata = ctl_rd;
            OFS_GCTL:   bus_rdata = gctl_q;
            OFS_WDOG:   bus_rdata = wdog_q;
            default:    bus_rdata = '0;
        endcase
    end

    assign tout_lo = tout[0];
    assign tout_hi = tout[1];
    assign irq     = evt[0] && ctl_q[IEN_BIT];

endmodule

// File: tb/dual_event_timer_bench.sv
module dual_event_timer_bench;
    localparam logic [5:0] A_EMU = 6'h04, A_CLO = 6'h10, A_CHI = 6'h14, A_PLO = 6'h18,
                           A_PHI = 6'h1C, A_CTL = 6'h20, A_GC = 6'h24, A_WD = 6'h28;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_we = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic tout_lo, tout_hi, irq;

    always #5 clk = ~clk;

    dual_event_timer u_dual_event_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tout_lo(tout_lo), .tout_hi(tout_hi), .irq(irq)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    int exp_lo[$], exp_hi[$], obs_lo[$];
    bit sb_on = 1'b1, tien_exp = 1'b0, inv_any = 1'b0;
    int last_wc = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        last_wc = cyc;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [31:0] expv, input string req);
        logic [31:0] v;
        rd(a, v);
        chk(v === expv, req, v, expv);
    endtask

    task automatic push_series(input bit hi, input int base, input int n, input int s);
        for (int t = base + n; t <= s; t += n) begin
            if (hi) exp_hi.push_back(t);
            else    exp_lo.push_back(t);
        end
    endtask

    // monitor: pops predicted events and compares their cycles
    always @(negedge clk) begin
        int e;
        if (rst_n) begin
            if (sb_on && !inv_any) begin
                if (tout_lo) begin
                    if (exp_lo.size() == 0) chk(1'b0, "R3 unexpected low event", cyc, 0);
                    else begin
                        e = exp_lo.pop_front();
                        chk(e == cyc, "R3 low event cycle", cyc, e);
                    end
                    chk(irq == tien_exp, "R9 irq on low event", irq, tien_exp);
                end else if (irq) chk(1'b0, "R9 irq without low event", 1, 0);
                if (tout_hi) begin
                    if (exp_hi.size() == 0) chk(1'b0, "R3 R4 unexpected high event", cyc, 0);
                    else begin
                        e = exp_hi.pop_front();
                        chk(e == cyc, "R3 R4 high event cycle", cyc, e);
                    end
                end
            end else if (!sb_on && tout_lo) obs_lo.push_back(cyc);
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base, s, w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(tout_lo == 0 && tout_hi == 0 && irq == 0, "R1 outputs after reset", {tout_lo, tout_hi, irq}, 0);
        rd_chk(A_EMU, 0, "R1 emu"); rd_chk(A_CLO, 0, "R1 cnt lo"); rd_chk(A_CHI, 0, "R1 cnt hi");
        rd_chk(A_PLO, 0, "R1 prd lo"); rd_chk(A_PHI, 0, "R1 prd hi"); rd_chk(A_CTL, 0, "R1 ctl");
        rd_chk(A_GC, 0, "R1 gctl"); rd_chk(A_WD, 0, "R1 wdog");

        // R2 map and reserved slots
        wr(6'h00, 32'hFFFF_FFFF); wr(6'h08, 32'hFFFF_FFFF); wr(6'h0C, 32'hFFFF_FFFF);
        rd_chk(6'h00, 0, "R2 reserved 0x00"); rd_chk(6'h08, 0, "R2 reserved 0x08"); rd_chk(6'h0C, 0, "R2 reserved 0x0C");
        wr(A_PLO, 32'hDEAD_BEEF); wr(A_PHI, 32'h1234_5678);
        rd_chk(A_PLO, 32'hDEAD_BEEF, "R2 prd lo readback"); rd_chk(A_PHI, 32'h1234_5678, "R2 prd hi readback");
        wr(A_WD, 32'hA5A5_0F0F); rd_chk(A_WD, 32'hA5A5_0F0F, "R11 watchdog stored");

        // R10 counter load, R6 gating
        wr(A_CLO, 32'h55); wr(A_CHI, 32'h77);
        rd_chk(A_CLO, 32'h55, "R10 cnt lo load"); rd_chk(A_CHI, 32'h77, "R10 cnt hi load");
        wr(A_CTL, 32'h0080_0080);
        repeat (20) @(negedge clk);
        rd_chk(A_CLO, 32'h55, "R6 lo held without release"); rd_chk(A_CHI, 32'h77, "R6 hi held without release");
        wr(A_GC, 32'h0000_000B);
        repeat (20) @(negedge clk);
        rd_chk(A_CLO, 32'h55, "R6 lo held in watchdog mode"); rd_chk(A_CHI, 32'h77, "R6 hi held in watchdog mode");
        wr(A_GC, 32'h0000_0005);
        repeat (10) @(negedge clk);
        rd(A_CLO, v); chk(v != 32'h55, "R6 lo counts once released", v, 32'h55);
        rd_chk(A_CHI, 32'h77, "R6 hi held, its release bit clear");
        wr(A_CTL, 0);

        // R3 continuous low half with inert fields set, R5 stop-and-hold
        wr(A_GC, 32'h0000_FF07); rd_chk(A_GC, 32'h0000_FF07, "R11 prescaler fields stored");
        wr(A_CLO, 0); wr(A_PLO, 4);
        tien_exp = 1'b1;
        wr(A_CTL, 32'h0000_03BC);
        base = last_wc; s = base + 23;
        push_series(1'b0, base, 5, s);
        repeat (21) @(negedge clk);
        wr(A_CTL, 32'h0000_033C);
        chk(last_wc == s, "R5 stop edge timing", last_wc, s);
        rd_chk(A_CLO, 3, "R5 count held after stop");
        repeat (5) @(negedge clk);
        rd_chk(A_CLO, 3, "R5 count still held");
        rd_chk(A_CTL, 32'h0000_033C, "R11 inert control bits stored, mode off");

        // R4 one-shot on high half
        tien_exp = 1'b0;
        wr(A_CHI, 0); wr(A_PHI, 2);
        wr(A_CTL, 32'h0040_0000);
        exp_hi.push_back(last_wc + 3);
        repeat (12) @(negedge clk);
        rd_chk(A_CTL, 0, "R4 one-shot mode field back to 00");
        rd_chk(A_CHI, 0, "R4 one-shot counter cleared");

        // R5 encoding 11 acts as off
        wr(A_CLO, 0); wr(A_CTL, 32'h0000_00C0);
        repeat (10) @(negedge clk);
        rd_chk(A_CLO, 0, "R5 mode 11 does not count");
        rd_chk(A_CTL, 0, "R5 mode 11 reads 00");

        // R3 both halves together, different periods
        wr(A_CLO, 0); wr(A_CHI, 0); wr(A_PLO, 2); wr(A_PHI, 3);
        wr(A_CTL, 32'h0080_0080);
        base = last_wc; s = base + 16;
        push_series(1'b0, base, 3, s);
        push_series(1'b1, base, 4, s);
        repeat (14) @(negedge clk);
        wr(A_CTL, 0);
        rd_chk(A_CLO, 1, "R3 lo count at stop");
        rd_chk(A_CHI, 0, "R3 hi count at stop");

        // R10 counter write while running
        wr(A_CLO, 0); wr(A_PLO, 9);
        wr(A_CTL, 32'h0000_0080);
        repeat (2) @(negedge clk);
        wr(A_CLO, 7);
        w = last_wc;
        push_series(1'b0, w - 7, 10, w + 14);
        repeat (12) @(negedge clk);
        wr(A_CTL, 0);
        chk(last_wc == w + 14, "R10 stop edge timing", last_wc, w + 14);
        rd_chk(A_CLO, 1, "R10 count resumed from written value");

        // R7 divisor of three
        wr(A_EMU, 32'h0003_0000); rd_chk(A_EMU, 32'h0003_0000, "R2 emu readback");
        sb_on = 1'b0;
        obs_lo.delete();
        wr(A_CLO, 0); wr(A_PLO, 3);
        wr(A_CTL, 32'h0000_0080);
        repeat (60) @(negedge clk);
        wr(A_CTL, 0);
        repeat (3) @(negedge clk);
        sb_on = 1'b1;
        chk(obs_lo.size() >= 3, "R7 events seen with divisor 3", obs_lo.size(), 3);
        for (int i = 0; i + 1 < obs_lo.size(); i++)
            chk(obs_lo[i+1] - obs_lo[i] == 12, "R7 event spacing with divisor 3", obs_lo[i+1] - obs_lo[i], 12);
        wr(A_EMU, 0);

        // R8 inversion and status
        inv_any = 1'b1;
        wr(A_CTL, 32'h0000_0002);
        chk(tout_lo == 1'b1, "R8 inverted idle low output", tout_lo, 1);
        chk(irq == 1'b0, "R9 irq unaffected by inversion", irq, 0);
        rd_chk(A_CTL, 32'h0000_0003, "R8 low status reflects output");
        wr(A_CTL, 32'h0002_0000);
        chk(tout_hi == 1'b1 && tout_lo == 1'b0, "R8 inverted idle high output", {tout_hi, tout_lo}, 2'b10);
        rd_chk(A_CTL, 32'h0003_0000, "R8 high status reflects output");
        wr(A_CTL, 0);
        @(negedge clk);
        inv_any = 1'b0;

        repeat (5) @(negedge clk);
        chk(exp_lo.size() == 0, "R3 low events all seen", exp_lo.size(), 0);
        chk(exp_hi.size() == 0, "R3 R4 high events all seen", exp_hi.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule